// File: doc/BRIEF.md
# MDIO Station Management Master

This block drives the two-wire management bus that a MAC uses to reach PHY registers. It makes the management clock from the host clock and runs one read or write frame at a time on a shared data line. That data line is presented as three separate signals: an output value, an output enable and an input sample. A host loads a divide value, the target PHY and register addresses, the direction and, for writes, 16 bits of data. It then pulses a start strobe. The block reports busy while the frame is on the wire. When the frame ends it pulses done and shows any read data, plus a flag raised when the PHY gave no answer.

The management clock period is twice (divide value + 1) host clocks. A divide value of zero is the power-up state and keeps the bus shut: the clock stays low and start requests are ignored. Outgoing bits change on falling management-clock edges. Incoming bits are sampled on rising edges. Each frame carries 64 bits in this order: preamble, start field, opcode, the two address fields, turnaround, and the 16-bit data field.

Top module: `mdio_master`

## Requirements
- R1: While the bus runs, `mdc_o` is high for (div+1) host clocks and low for (div+1) host clocks, so its period is 2*(div+1) host clocks.
- R2: When `div_i` is 0, a start strobe is ignored (`busy_o` stays 0), and `mdc_o` is held low in the following cycle unless a frame is in progress.
- R3: When `enable_i` is 0, a start strobe is ignored and `busy_o` stays 0.
- R4: Bit 0 of a frame is launched on the first falling `mdc_o` edge after the start is accepted. Frame bits 0 to 31 are all 1, with `mdio_oe_o` high.
- R5: Frame bits 32 to 45 are sent in this order: the start field 0,1; the opcode, which is 1,0 for a read (`rd_i`=1) and 0,1 for a write (`rd_i`=0); then `phy_addr_i` and `reg_addr_i`, each MSB first. `mdio_oe_o` is high for all of these bits.
- R6: On a write, frame bits 46 and 47 are 1 then 0, and bits 48 to 63 are `wdata_i` MSB first. `mdio_oe_o` stays high for all 64 bits.
- R7: On a read, `mdio_oe_o` is low from frame bit 46 through bit 63. `mdio_i` is sampled on the rising `mdc_o` edges of bits 48 to 63 and assembled MSB first. The result appears on `rdata_o` in the cycle `done_o` pulses and is held until the next read completes.
- R8: At the end of a read, `no_resp_o` is set to the value of `mdio_i` sampled during bit 47. At the end of a write, `no_resp_o` is cleared.
- R9: After reset all outputs are 0. `busy_o` rises in the cycle after the start is accepted and falls in the cycle `done_o` pulses. `done_o` lasts one host clock per frame. `mdio_oe_o` is 0 once the frame ends.
- R10: A start strobe while `busy_o` is high is ignored. The running frame keeps its latched fields, and no extra frame or done pulse follows.
- R11: While `mdio_oe_o` stays high, `mdio_o` changes only in the cycle in which `mdc_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 5 | Clock divide value; 0 disables the bus |
| enable_i | input | 1 | Bus enable |
| start_i | input | 1 | Start strobe for one frame |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Last read data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| no_resp_o | output | 1 | PHY did not drive the second turnaround bit low |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Each frame is fully serial, so a bit counter or shift register that is off by one position shows up as a misplaced bit in the captured 64-bit frame within one MDC period of the fault. A wrong direction latch shows at bit 46, where `mdio_oe_o` either drops on a write or stays high on a read. A divider fault shows as a wrong MDC period between any two rising edges, long before the frame completes. A wrong sequencer state shows as a missing or repeated done pulse, or as `busy_o` staying high.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARM,
    SEQ_RUN
  } seq_st_e;

  localparam logic [1:0] ST_FIELD = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam int unsigned HDR_W   = 4;  // start field + opcode
  localparam int unsigned TA_W    = 2;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q >= div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 64,
  parameter int unsigned TA_IDX    = 46
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic rd_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic busy_o,
  output logic shift_o,
  output logic end_o,
  output logic oe_o,
  output logic samp_ta_o,
  output logic samp_dat_o,
  output logic rd_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA1_BIT  = CNT_W'(TA_IDX);
  localparam logic [CNT_W-1:0] TA2_BIT  = CNT_W'(TA_IDX + 1);
  localparam logic [CNT_W-1:0] DAT_BIT  = CNT_W'(TA_IDX + 2);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q;
  logic             done_q;
  logic             in_run;

  assign in_run     = (st_q == SEQ_RUN);
  assign busy_o     = (st_q != SEQ_IDLE);
  assign end_o      = in_run && fall_i && (cnt_q == LAST_BIT);
  assign shift_o    = in_run && fall_i && (cnt_q != LAST_BIT);
  assign oe_o       = in_run && !(rd_q && (cnt_q >= TA1_BIT));
  assign samp_ta_o  = in_run && rise_i && rd_q && (cnt_q == TA2_BIT);
  assign samp_dat_o = in_run && rise_i && rd_q && (cnt_q >= DAT_BIT);
  assign rd_o       = rd_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: if (accept_i) begin
          st_q <= SEQ_ARM;
          rd_q <= rd_i;
        end
        // wait for the first falling edge to launch bit 0
        SEQ_ARM: if (fall_i) begin
          st_q  <= SEQ_RUN;
          cnt_q <= '0;
        end
        SEQ_RUN: if (fall_i) begin
          if (cnt_q == LAST_BIT) begin
            st_q   <= SEQ_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_shift.sv
`timescale 1ns/1ps
module mdio_shift #(
  parameter int unsigned FRAME_LEN = 64,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 shift_i,
  input  logic                 samp_ta_i,
  input  logic                 samp_dat_i,
  input  logic                 end_i,
  input  logic                 rd_i,
  input  logic                 line_i,
  output logic                 tx_bit_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 no_resp_o
);
  logic [FRAME_LEN-1:0] tx_q;
  logic [DATA_W-1:0]    rx_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 ta_q;
  logic                 nr_q;

  assign tx_bit_o  = tx_q[FRAME_LEN-1];
  assign rdata_o   = rdata_q;
  assign no_resp_o = nr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= frame_i;
    end else if (shift_i) begin
      tx_q <= {tx_q[FRAME_LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= '0;
      ta_q    <= 1'b0;
      rdata_q <= '0;
      nr_q    <= 1'b0;
    end else begin
      if (samp_ta_i)  ta_q <= line_i;
      if (samp_dat_i) rx_q <= {rx_q[DATA_W-2:0], line_i};
      if (end_i) begin
        if (rd_i) rdata_q <= rx_q;
        nr_q <= rd_i && ta_q;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              enable_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              no_resp_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int unsigned TA_IDX    = PRE_LEN + HDR_W + 2 * ADDR_W;
  localparam int unsigned FRAME_LEN = TA_IDX + TA_W + DATA_W;

  logic                 busy;
  logic                 accept;
  logic [DIV_W-1:0]     div_q;
  logic [DIV_W-1:0]     div_cur;
  logic                 clk_run;
  logic                 rise, fall;
  logic                 shift_en, frame_end, oe, samp_ta, samp_dat, rd_lat;
  logic                 tx_bit;
  logic [FRAME_LEN-1:0] frame;

  // zero divide locks the bus off
  assign accept  = start_i && !busy && enable_i && (div_i != '0);
  assign div_cur = busy ? div_q : div_i;
  assign clk_run = busy || (enable_i && (div_i != '0));

  assign frame = {{PRE_LEN{1'b1}}, ST_FIELD, (rd_i ? OP_RD : OP_WR),
                  phy_addr_i, reg_addr_i,
                  (rd_i ? 2'b00 : TA_WR),
                  (rd_i ? {DATA_W{1'b0}} : wdata_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (accept) div_q <= div_i;
  end

  mdio_clk_div #(.DIV_W(DIV_W)) i_clk_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (clk_run),
    .div_i  (div_cur),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_seq #(.FRAME_LEN(FRAME_LEN), .TA_IDX(TA_IDX)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .rd_i       (rd_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .busy_o     (busy),
    .shift_o    (shift_en),
    .end_o      (frame_end),
    .oe_o       (oe),
    .samp_ta_o  (samp_ta),
    .samp_dat_o (samp_dat),
    .rd_o       (rd_lat),
    .done_o     (done_o)
  );

  mdio_shift #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .frame_i    (frame),
    .shift_i    (shift_en),
    .samp_ta_i  (samp_ta),
    .samp_dat_i (samp_dat),
    .end_i      (frame_end),
    .rd_i       (rd_lat),
    .line_i     (mdio_i),
    .tx_bit_o   (tx_bit),
    .rdata_o    (rdata_o),
    .no_resp_o  (no_resp_o)
  );

  assign busy_o    = busy;
  assign mdio_oe_o = oe;
  assign mdio_o    = oe & tx_bit;
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int unsigned DIV_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] div_i,
  input logic             enable_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o
);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  a_r2_start_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (div_i == '0)) |=> !busy_o);

  a_r2_mdc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (div_i == '0)) |=> !mdc_o);

  a_r3_start_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !enable_i) |=> !busy_o);

  a_r11_launch_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_o && $past(mdio_oe_o) && (mdio_o != $past(mdio_o))) |-> $fell(mdc_o));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_i     (div_i),
  .enable_i  (enable_i),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  div_i = '0;
  logic        enable_i = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, no_resp_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  mdio_master i_mdio_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .enable_i(enable_i),
    .start_i(start_i), .rd_i(rd_i), .phy_addr_i(phy_addr_i),
    .reg_addr_i(reg_addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o), .no_resp_o(no_resp_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY model and line monitor, sampled on the falling host clock
  logic        cap_bit [64];
  logic        cap_oe  [64];
  int          rcnt = 0;
  int          frame_len = 0;
  int          cyc = 0;
  int          last_rise = -1;
  int          period = 0;
  int          r11_viol = 0;
  int          rises_seen = 0;
  logic [15:0] phy_data = '0;
  logic        phy_ta2 = 1'b0;
  logic        mdc_prev = 1'b0, oe_prev = 1'b0, dat_prev = 1'b0;

  always @(negedge clk_i) begin
    cyc++;
    if (mdc_o && !mdc_prev) begin
      rises_seen++;
      if (busy_o && (mdio_oe_o || rcnt != 0) && rcnt < 64) begin
        cap_bit[rcnt] = mdio_o;
        cap_oe[rcnt]  = mdio_oe_o;
        rcnt++;
        if (rcnt >= 2) period = cyc - last_rise;
      end
      last_rise = cyc;
    end
    if (!mdc_o && mdc_prev) begin
      if (rcnt == 47)                   mdio_i = phy_ta2;
      else if (rcnt >= 48 && rcnt < 64) mdio_i = phy_data[63-rcnt];
      else                              mdio_i = 1'b1;
    end
    if (mdio_oe_o && oe_prev && (mdio_o != dat_prev) && !(mdc_prev && !mdc_o))
      r11_viol++;
    if (done_o) begin
      frame_len = rcnt;
      rcnt = 0;
    end
    mdc_prev = mdc_o;
    oe_prev  = mdio_oe_o;
    dat_prev = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [4:0] dv,
                           input bit ta2, input logic [15:0] pdata, input bit restart);
    logic [63:0] exp;
    int n;
    bit ok;
    phy_data = pdata;
    phy_ta2  = ta2;
    @(negedge clk_i);
    div_i = dv; enable_i = 1'b1; rd_i = rd;
    phy_addr_i = phy; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after accept", busy_o, 1);
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
      if (restart && n == 40 * (dv + 1)) begin
        start_i = 1'b1; rd_i = ~rd; phy_addr_i = ~phy; reg_addr_i = ~ra; wdata_i = ~wd;
      end
    end
    chk(done_o == 1'b1, "R9", "done seen", done_o, 1);
    chk(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
    if (rd) chk(rdata_o == pdata, "R7", "read data", rdata_o, pdata);
    chk(no_resp_o == (rd && ta2), "R8", "no response flag", no_resp_o, rd && ta2);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9", "done width", done_o, 0);
    chk(frame_len == 64, "R4", "frame length", frame_len, 64);
    exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
    ok = 1'b1;
    for (int k = 0; k < 32; k++) if (cap_bit[k] !== 1'b1 || cap_oe[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R4", "preamble", 0, 0);
    ok = 1'b1;
    for (int k = 32; k < 46; k++) if (cap_bit[k] !== exp[63-k] || cap_oe[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R5", "start/op/addresses", {cap_bit[32], cap_bit[33], cap_bit[34], cap_bit[35]},
        exp[31:28]);
    ok = 1'b1;
    for (int k = 46; k < 64; k++) begin
      if (rd) begin
        if (cap_oe[k] !== 1'b0) ok = 1'b0;
      end else if (cap_bit[k] !== exp[63-k] || cap_oe[k] !== 1'b1) ok = 1'b0;
    end
    chk(ok, rd ? "R7" : "R6", "turnaround and data phase", 0, 0);
    chk(period == 2 * (dv + 1), "R1", "mdc period", period, 2 * (dv + 1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!busy_o && !done_o && !mdio_oe_o, "R10", "idle after frame",
          {busy_o, done_o, mdio_oe_o}, 0);
    end
  endtask

  task automatic blocked(input logic [4:0] dv, input bit en, input string req);
    int r0;
    bit seen_busy;
    @(negedge clk_i);
    div_i = dv; enable_i = en; start_i = 1'b1; rd_i = 1'b1;
    r0 = rises_seen;
    seen_busy = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk_i);
      if (busy_o) seen_busy = 1'b1;
    end
    chk(!seen_busy, req, "start ignored", seen_busy, 0);
    chk(rises_seen == r0 && !mdc_o, req, "mdc idle", rises_seen - r0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, done_o, mdc_o, mdio_oe_o, mdio_o, no_resp_o} == 6'b0 && rdata_o == 16'h0,
        "R9", "reset state", {busy_o, done_o, mdc_o, mdio_oe_o}, 0);
    blocked(5'd0, 1'b1, "R2");
    blocked(5'd3, 1'b0, "R3");
    for (int d = 1; d <= 8; d++) begin
      run_frame(1'b0, 5'(d * 3), 5'(31 - d), 16'(16'hA5C3 ^ (d * 16'h1111)), 5'(d),
                1'b0, 16'h0, 1'b0);
      run_frame(1'b1, 5'(d * 5), 5'(d), 16'h0, 5'(d), 1'b0,
                16'(16'h8001 + d * 16'h0F0F), 1'b0);
    end
    run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 5'd31, 1'b0, 16'hFFFF, 1'b0);
    run_frame(1'b0, 5'h00, 5'h1F, 16'h0000, 5'd31, 1'b0, 16'h0, 1'b0);
    run_frame(1'b1, 5'h0A, 5'h15, 16'h0, 5'd2, 1'b1, 16'h1234, 1'b0);  // R8 no answer
    run_frame(1'b0, 5'h0A, 5'h15, 16'hBEEF, 5'd2, 1'b0, 16'h0, 1'b0);  // R8 cleared
    run_frame(1'b1, 5'h11, 5'h06, 16'h0, 5'd1, 1'b0, 16'h5AA5, 1'b1);  // R10 restart
    run_frame(1'b0, 5'h03, 5'h19, 16'h6C39, 5'd4, 1'b0, 16'h0, 1'b1);  // R10 restart
    chk(r11_viol == 0, "R11", "launch only on falling mdc", r11_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule